// File: doc/BRIEF.md
# Programmable Clock Output Channel

This block is one output lane of a clock fan-out device. Three candidate clocks arrive as clock-enable strobes (one strobe per source clock cycle) inside a single fast clock domain. The lane selects one of them and divides it by a programmable ratio. After a sync request it holds its output low for a programmable number of source cycles, so that every lane restarts in a known phase. The result drives two single-ended pins, and each pin has its own mode.

All settings come from a 28-bit configuration word. The lane does not follow that word continuously. It takes a fresh copy at each sync and at the start of each output period, so a write made while the lane runs never shortens or stretches the period in progress. The host writes the word and then pulls the sync input low to apply it at once across all lanes.

Top module: `clk_out_channel`

## Requirements
- R1: Bits [5:4] of the configuration word pick the source: 00 primary, 01 secondary, 10 auxiliary. Strobes from a source that is not picked have no effect. The value 11 means no clock: the output freezes, and only a sync can apply a new setting.
- R2: Bits [19:13] hold N−1, where N is the divide ratio. For N ≥ 2 the output repeats every N selected strobes. It is high for floor(N/2) of them, starting with the first strobe of the period, and low for the rest.
- R3: A ratio field above 79 gives N = 80.
- R4: With N = 1 the output is high in the fast-clock cycle after each selected strobe and low otherwise.
- R5: Bit 20 enables the divider. While it is 0 the divided clock is held low. Once the bit is set again, the next selected strobe starts a period, with no sync needed.
- R6: A falling edge on `sync_n` forces the divided clock low. The first rising edge then comes on selected strobe number (P mod N)+1, where P is bits [12:6].
- R7: Bits [23:22] set the mode of the positive pin and bits [25:24] set the mode of the negative pin. 00 follows the divided clock, 10 is its complement, 11 drives low, and 01 sets the pin's output enable low with the data low.
- R8: A change to the ratio, enable, source or pin modes takes effect only at the next period start or the next sync. The period in progress completes unchanged.
- R9: After reset both pins are driven low with their output enables high.
- R10: Keeping `sync_n` low after its falling edge does not restart the lane again. Counting continues normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the whole lane |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_tick | input | 1 | One-cycle strobe per primary source cycle |
| sec_tick | input | 1 | One-cycle strobe per secondary source cycle |
| aux_tick | input | 1 | One-cycle strobe per auxiliary source cycle |
| sync_n | input | 1 | Active-low realignment request; acts on its falling edge |
| cfg | input | 28 | Configuration word |
| out_p | output | 1 | Positive pin data |
| out_p_oe | output | 1 | Positive pin output enable |
| out_n | output | 1 | Negative pin data |
| out_n_oe | output | 1 | Negative pin output enable |

## Verification
The bench targets odd ratios, where a lane that rounds the high time up would show one extra high strobe per period. It tests the clamp at ratio fields 79, 100 and 127: a lane that does not clamp would wrap to a short period. It uses phase offsets larger than the ratio, which catch a lane that skips the modulo and starts late. Further cases cover a configuration write in the middle of a period, which a lane that loads settings at once would show as a shortened period or an early mode flip. They also cover the reserved source, where a lane that kept loading settings at period starts would come back to life without a sync, and a held-low sync, which a level-sensitive lane would treat as a frozen output.

// File: rtl/clk_out_channel.sv
module clk_out_channel #(
  parameter int CFG_W   = 28,
  parameter int DIV_W   = 7,
  parameter int MAX_DIV = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pri_tick,
  input  logic             sec_tick,
  input  logic             aux_tick,
  input  logic             sync_n,
  input  logic [CFG_W-1:0] cfg,
  output logic             out_p,
  output logic             out_p_oe,
  output logic             out_n,
  output logic             out_n_oe
);

  localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);
  localparam logic [DIV_W-1:0] NMAX = DIV_W'(MAX_DIV);

  logic [1:0]       cfg_src, cfg_mp, cfg_mn;
  logic [DIV_W-1:0] cfg_ph, cfg_rat, cfg_n, cfg_d;
  logic             cfg_en;

  assign cfg_src = cfg[5:4];
  assign cfg_ph  = cfg[12:6];
  assign cfg_rat = cfg[19:13];
  assign cfg_en  = cfg[20];
  assign cfg_mp  = cfg[23:22];
  assign cfg_mn  = cfg[25:24];

  logic unused_cfg;
  assign unused_cfg = ^{cfg[3:0], cfg[CFG_W-1:26]};

  assign cfg_n = (cfg_rat >= NMAX) ? NMAX : cfg_rat + ONE;
  assign cfg_d = cfg_ph % cfg_n;

  logic [1:0]       src_a, mp_a, mn_a;
  logic [DIV_W-1:0] n_a, cnt, dly;
  logic             en_a, armed, q, sync_q;
  logic             sel_tick, sync_pulse, boundary;

  always_comb begin
    case (src_a)
      2'b00:   sel_tick = pri_tick;
      2'b01:   sel_tick = sec_tick;
      2'b10:   sel_tick = aux_tick;
      default: sel_tick = 1'b0;
    endcase
  end

  assign sync_pulse = sync_q & ~sync_n;
  assign boundary   = !en_a || (armed && dly == '0) || (!armed && cnt == n_a - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_a  <= 2'b00;
      mp_a   <= 2'b00;
      mn_a   <= 2'b00;
      n_a    <= ONE;
      en_a   <= 1'b0;
      cnt    <= '0;
      dly    <= '0;
      armed  <= 1'b1;
      q      <= 1'b0;
      sync_q <= 1'b1;
    end else begin
      sync_q <= sync_n;
      if (sync_pulse) begin
        src_a <= cfg_src;
        mp_a  <= cfg_mp;
        mn_a  <= cfg_mn;
        n_a   <= cfg_n;
        en_a  <= cfg_en;
        dly   <= cfg_d;
        cnt   <= '0;
        armed <= 1'b1;
        q     <= 1'b0;
      end else if (sel_tick) begin
        if (boundary) begin
          src_a <= cfg_src;
          mp_a  <= cfg_mp;
          mn_a  <= cfg_mn;
          n_a   <= cfg_n;
          en_a  <= cfg_en;
          cnt   <= '0;
          dly   <= '0;
          armed <= !cfg_en;
          q     <= cfg_en;
        end else if (armed) begin
          dly <= dly - ONE;
        end else begin
          cnt <= cnt + ONE;
          q   <= (cnt + ONE) < (n_a >> 1);
        end
      end else if (n_a == ONE && !armed) begin
        q <= 1'b0;
      end
    end
  end

  function automatic logic pin_val(input logic [1:0] m, input logic v);
    case (m)
      2'b00:   return v;
      2'b10:   return ~v;
      default: return 1'b0;
    endcase
  endfunction

  assign out_p    = pin_val(mp_a, q);
  assign out_n    = pin_val(mn_a, q);
  assign out_p_oe = (mp_a != 2'b01);
  assign out_n_oe = (mn_a != 2'b01);

endmodule

// File: rtl/clk_out_channel_chk.sv
module clk_out_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_n,
  input logic       sel_tick,
  input logic       en_a,
  input logic       q,
  input logic [1:0] src_a,
  input logic       out_p,
  input logic       out_p_oe,
  input logic       out_n,
  input logic       out_n_oe
);

  AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == 2'b11 && sync_n) |=> $stable(q)); // R1

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(sel_tick)); // R2

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |-> !q); // R5

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |=> !q); // R6

  AST_TRI_P_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_p_oe |-> !out_p); // R7

  AST_TRI_N_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_n_oe |-> !out_n); // R7

endmodule

bind clk_out_channel clk_out_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sel_tick(sel_tick),
  .en_a(en_a), .q(q), .src_a(src_a), .out_p(out_p), .out_p_oe(out_p_oe),
  .out_n(out_n), .out_n_oe(out_n_oe)
);

// File: tb/tb_clk_out_channel.sv
`timescale 1ns/1ps
module tb_clk_out_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pri = 1'b0, sec = 1'b0, aux = 1'b0, sync_n = 1'b1;
  logic [27:0] cfg = '0;
  logic out_p, out_p_oe, out_n, out_n_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  clk_out_channel dut (
    .clk(clk), .rst_n(rst_n), .pri_tick(pri), .sec_tick(sec), .aux_tick(aux),
    .sync_n(sync_n), .cfg(cfg), .out_p(out_p), .out_p_oe(out_p_oe),
    .out_n(out_n), .out_n_oe(out_n_oe));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic set_cfg(input logic [1:0] src, input int ph, input int rat,
                         input bit en, input logic [1:0] mp, input logic [1:0] mn);
    cfg = '0;
    cfg[5:4]   = src;
    cfg[12:6]  = 7'(ph);
    cfg[19:13] = 7'(rat);
    cfg[20]    = en;
    cfg[23:22] = mp;
    cfg[25:24] = mn;
  endtask

  task automatic tick(input int s);
    @(negedge clk);
    pri = (s == 0); sec = (s == 1); aux = (s == 2);
    @(negedge clk);
    pri = 1'b0; sec = 1'b0; aux = 1'b0;
  endtask

  task automatic do_sync;
    @(negedge clk) sync_n = 1'b0;
    @(negedge clk) sync_n = 1'b1;
  endtask

  task automatic t_reset;
    check(out_p == 0, "R9 out_p", out_p, 0);
    check(out_n == 0, "R9 out_n", out_n, 0);
    check(out_p_oe == 1 && out_n_oe == 1, "R9 oe", {out_p_oe, out_n_oe}, 3);
  endtask

  task automatic t_pattern(input int src, input int field, input int n, input string tag);
    set_cfg(2'(src), 0, field, 1'b1, 2'b00, 2'b00);
    do_sync;
    check(out_p == 0, "R6 low after sync", out_p, 0);
    for (int k = 0; k < 2 * n; k++) begin
      int e;
      tick(src);
      e = (n == 1) ? 1 : (((k % n) < n / 2) ? 1 : 0);
      check(out_p == e, tag, out_p, e);
      if (n == 1) begin
        @(negedge clk);
        check(out_p == 0, "R4 drop", out_p, 0);
      end
    end
  endtask

  task automatic t_phase(input int n, input int d);
    int k = 0;
    set_cfg(2'b00, d, n - 1, 1'b1, 2'b00, 2'b00);
    do_sync;
    while (out_p == 0 && k < 200) begin tick(0); k++; end
    check(k == (d % n) + 1, "R6 first edge", k, (d % n) + 1);
  endtask

  task automatic t_other_src;
    set_cfg(2'b00, 0, 3, 1'b1, 2'b00, 2'b00);
    do_sync;
    tick(1); tick(2); tick(1);
    check(out_p == 0, "R1 unselected ignored", out_p, 0);
    tick(0);
    check(out_p == 1, "R1 selected counts", out_p, 1);
  endtask

  task automatic t_reserved;
    set_cfg(2'b11, 0, 1, 1'b1, 2'b00, 2'b00);
    do_sync;
    tick(0); tick(1); tick(2);
    check(out_p == 0, "R1 reserved frozen", out_p, 0);
    set_cfg(2'b00, 0, 1, 1'b1, 2'b00, 2'b00);
    tick(0); tick(0);
    check(out_p == 0, "R1 reserved needs sync", out_p, 0);
    do_sync;
    tick(0);
    check(out_p == 1, "R1 recovers after sync", out_p, 1);
  endtask

  task automatic t_disable;
    set_cfg(2'b00, 0, 1, 1'b0, 2'b10, 2'b00);
    do_sync;
    for (int k = 0; k < 4; k++) begin
      tick(0);
      check(out_n == 0, "R5 held low", out_n, 0);
      check(out_p == 1, "R5 inverted static", out_p, 1);
    end
    set_cfg(2'b00, 0, 1, 1'b1, 2'b00, 2'b00);
    tick(0);
    check(out_p == 1, "R5 re-enable starts", out_p, 1);
    tick(0);
    check(out_p == 0, "R5 re-enable period", out_p, 0);
  endtask

  task automatic t_modes;
    set_cfg(2'b00, 0, 1, 1'b1, 2'b10, 2'b00);
    do_sync;
    check(out_p == 1 && out_n == 0, "R7 inv idle", {out_p, out_n}, 2);
    tick(0);
    check(out_p == 0 && out_n == 1, "R7 inv high", {out_p, out_n}, 1);
    set_cfg(2'b00, 0, 1, 1'b1, 2'b11, 2'b01);
    do_sync;
    tick(0);
    check(out_p == 0 && out_p_oe == 1, "R7 low mode", {out_p, out_p_oe}, 1);
    check(out_n == 0 && out_n_oe == 0, "R7 tristate", {out_n, out_n_oe}, 0);
  endtask

  task automatic t_midchange;
    int exp_seq[9] = '{0, 0, 1, 1, 1, 0, 0, 0, 1};
    set_cfg(2'b00, 0, 3, 1'b1, 2'b00, 2'b00);
    do_sync;
    tick(0); tick(0);
    set_cfg(2'b00, 0, 5, 1'b1, 2'b00, 2'b00);
    for (int k = 0; k < 9; k++) begin
      tick(0);
      check(out_p == exp_seq[k], "R8 ratio at boundary", out_p, exp_seq[k]);
    end
    set_cfg(2'b00, 0, 1, 1'b1, 2'b00, 2'b00);
    do_sync;
    tick(0);
    set_cfg(2'b00, 0, 1, 1'b1, 2'b10, 2'b00);
    @(negedge clk);
    check(out_p == 1, "R8 mode held", out_p, 1);
    tick(0);
    check(out_p == 0, "R8 mode held low", out_p, 0);
    tick(0);
    check(out_p == 0, "R8 mode applied", out_p, 0);
  endtask

  task automatic t_sync_hold;
    int exp_seq[5] = '{1, 1, 0, 0, 1};
    set_cfg(2'b00, 0, 3, 1'b1, 2'b00, 2'b00);
    @(negedge clk) sync_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick(0);
      check(out_p == exp_seq[k], "R10 held sync", out_p, exp_seq[k]);
    end
    @(negedge clk) sync_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_pattern(0, 1, 2, "R2 ratio 2");
    t_pattern(0, 4, 5, "R2 odd ratio 5");
    t_pattern(1, 6, 7, "R1 secondary ratio 7");
    t_pattern(2, 2, 3, "R1 auxiliary ratio 3");
    t_pattern(0, 0, 1, "R4 ratio 1");
    t_pattern(0, 79, 80, "R3 ratio 80");
    t_pattern(0, 100, 80, "R3 clamp 100");
    t_pattern(0, 127, 80, "R3 clamp 127");
    t_phase(8, 3);
    t_phase(5, 12);
    t_phase(4, 0);
    t_phase(1, 9);
    t_other_src;
    t_reserved;
    t_disable;
    t_modes;
    t_midchange;
    t_sync_hold;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule